// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Overflow Status

This block is a 32-bit two's-complement arithmetic unit. It performs a multiply-accumulate (A times B plus C) and a multiply-subtract (A times B minus C). It also performs a plain add (A plus C) and a plain subtract (A minus C). A start strobe launches one operation. One clock later the unit presents the 32-bit result with four status flags: overflow, carry, zero and sign. A done strobe marks that cycle.

Overflow is computed across the whole chain of every opcode. On the multiply opcodes, the flag is raised in two cases:
- the full 64-bit signed product does not fit in 32 signed bits;
- the following 32-bit add or subtract of C wraps.

No opcode leaves the flag unchanged. The result and the flags are written on every accepted operation and hold their values until the next one.

Top module: `smacc_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, result, done and all four flags read zero.
- R2: Opcode 2'b00 returns A plus C and opcode 2'b01 returns A minus C, both modulo 2^32. Operand B has no effect on these two opcodes.
- R3: Opcode 2'b10 returns the low 32 bits of A times B plus C.
- R4: Opcode 2'b11 returns the low 32 bits of A times B minus C.
- R5: On add, overflow is set exactly when A and C share a sign bit and the result's sign bit differs from it. On subtract, the same rule is applied with C negated, which is the true signed difference leaving the 32-bit range.
- R6: On opcodes 2'b10 and 2'b11, overflow is set when either of these holds: the 64-bit signed product of A and B lies outside the 32-bit signed range, or the 32-bit add or subtract of C applied to the low product word leaves the signed range. For example, 0x7FFFFFFF times 2 plus 0 sets overflow.
- R7: Zero is high exactly when the 32-bit result is all zeros. Sign equals result bit 31.
- R8: Carry is the unsigned carry-out of the final stage. On add and multiply-accumulate it is set when the unsigned sum of the first term and C reaches 2^32. On subtract and multiply-subtract it is set when the first term is greater than or equal to C as unsigned values, meaning no borrow. The first term is A for add and subtract, and the low product word for the multiply opcodes.
- R9: Result and flags update on the clock edge that samples start high. Done is high for exactly that following cycle, and done is high only after a start.
- R10: When start is low, result and all flags hold their previous values, whatever the operands and opcode are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation with the present operands and opcode |
| opcode | input | 2 | 00 add, 01 subtract, 10 multiply-accumulate, 11 multiply-subtract |
| op_a | input | 32 | First multiplicand, or first addend for add and subtract |
| op_b | input | 32 | Second multiplicand |
| op_c | input | 32 | Accumulate or subtract operand |
| result | output | 32 | Registered result |
| done | output | 1 | One-cycle pulse when result and flags are new |
| flag_ovf | output | 1 | Signed overflow over the full chain |
| flag_carry | output | 1 | Unsigned carry-out or no-borrow of the final stage |
| flag_zero | output | 1 | Result is zero |
| flag_sign | output | 1 | Result bit 31 |

## Verification
Each output is registered one stage after the inputs. A wrong product-range decision, a wrong stage carry or a wrong operand selection therefore appears at the ports in the single cycle after the start that caused it. The fault is then held there until the next start. Faults that only touch the upper half of the product are the hardest to see: they surface in the overflow flag and nowhere else. For that reason the stimulus mixes corner operands with random operands, so that the product-range check and the stage-wrap check are each triggered alone and together. A hold fault shows up as an output change on a cycle with start low, and the randomized idle operands make that change likely.

// File: rtl/smacc_pkg.sv
`timescale 1ns/1ps
package smacc_pkg;

    typedef enum logic [1:0] {
        SM_ADD = 2'b00,
        SM_SUB = 2'b01,
        SM_MAC = 2'b10,
        SM_MSB = 2'b11
    } smacc_op_e;

    typedef struct packed {
        logic ovf;
        logic carry;
        logic zero;
        logic sign;
    } smacc_flags_t;

    localparam smacc_flags_t SM_FLAGS_CLEAR = '{ovf: 1'b0, carry: 1'b0, zero: 1'b0, sign: 1'b0};

    function automatic logic uses_product(input smacc_op_e op);
        return (op == SM_MAC) || (op == SM_MSB);
    endfunction

    function automatic logic subtracts(input smacc_op_e op);
        return (op == SM_SUB) || (op == SM_MSB);
    endfunction

endpackage

// File: rtl/smacc_mul.sv
`timescale 1ns/1ps
module smacc_mul #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] mul_a,
    input  logic [W-1:0] mul_b,
    output logic [W-1:0] prod_lo,
    output logic         prod_wide
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] ext_a;
    logic [PW-1:0] ext_b;
    logic [PW-1:0] full;
    logic [W:0]    top_bits;

    // Sign-extend both operands so the low 2W bits of the unsigned
    // product equal the signed product.
    assign ext_a = {{W{mul_a[W-1]}}, mul_a};
    assign ext_b = {{W{mul_b[W-1]}}, mul_b};
    assign full  = ext_a * ext_b;

    assign prod_lo  = full[W-1:0];
    // The product fits in W signed bits only when bits PW-1 .. W-1 agree.
    assign top_bits  = full[PW-1:W-1];
    assign prod_wide = !((&top_bits) || (~|top_bits));
endmodule

// File: rtl/smacc_addsub.sv
`timescale 1ns/1ps
module smacc_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         carry_out,
    output logic         wrap
);
    logic [W-1:0] rhs_eff;
    logic [W:0]   wide_sum;

    // Subtraction as lhs + ~rhs + 1; carry-out then means "no borrow".
    assign rhs_eff   = do_sub ? ~rhs : rhs;
    assign wide_sum  = {1'b0, lhs} + {1'b0, rhs_eff} + {{W{1'b0}}, do_sub};
    assign sum       = wide_sum[W-1:0];
    assign carry_out = wide_sum[W];
    assign wrap      = (lhs[W-1] == rhs_eff[W-1]) && (sum[W-1] != lhs[W-1]);
endmodule

// File: rtl/smacc_unit.sv
`timescale 1ns/1ps
module smacc_unit
    import smacc_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [1:0]   opcode,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] op_c,
    output logic [W-1:0] result,
    output logic         done,
    output logic         flag_ovf,
    output logic         flag_carry,
    output logic         flag_zero,
    output logic         flag_sign
);
    smacc_op_e    op;
    logic [W-1:0] prod_lo;
    logic         prod_wide;
    logic [W-1:0] first_term;
    logic [W-1:0] stage_sum;
    logic         stage_carry;
    logic         stage_wrap;
    smacc_flags_t next_flags;
    smacc_flags_t flags_q;
    logic [W-1:0] result_q;
    logic         done_q;

    assign op = smacc_op_e'(opcode);

    smacc_mul #(.W(W)) i_mul (
        .mul_a     (op_a),
        .mul_b     (op_b),
        .prod_lo   (prod_lo),
        .prod_wide (prod_wide)
    );

    assign first_term = uses_product(op) ? prod_lo : op_a;

    smacc_addsub #(.W(W)) i_addsub (
        .lhs       (first_term),
        .rhs       (op_c),
        .do_sub    (subtracts(op)),
        .sum       (stage_sum),
        .carry_out (stage_carry),
        .wrap      (stage_wrap)
    );

    // Overflow covers the whole chain: the product range on the multiply
    // opcodes, combined with the wrap of the final stage on every opcode.
    always_comb begin
        next_flags.ovf   = stage_wrap || (uses_product(op) && prod_wide);
        next_flags.carry = stage_carry;
        next_flags.zero  = (stage_sum == '0);
        next_flags.sign  = stage_sum[W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flags_q  <= SM_FLAGS_CLEAR;
            done_q   <= 1'b0;
        end else begin
            done_q <= start;
            if (start) begin
                result_q <= stage_sum;
                flags_q  <= next_flags;
            end
        end
    end

    assign result     = result_q;
    assign done       = done_q;
    assign flag_ovf   = flags_q.ovf;
    assign flag_carry = flags_q.carry;
    assign flag_zero  = flags_q.zero;
    assign flag_sign  = flags_q.sign;
endmodule

// File: rtl/smacc_unit_chk.sv
`timescale 1ns/1ps
module smacc_unit_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [1:0]   opcode,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [W-1:0] op_c,
    input logic [W-1:0] result,
    input logic         done,
    input logic         flag_ovf,
    input logic         flag_carry,
    input logic         flag_zero,
    input logic         flag_sign
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] TWO     = W'(2);

    assert_done_after_start_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    assert_done_only_after_start_R9: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(result) && $stable(flag_ovf) && $stable(flag_carry)
                    && $stable(flag_zero) && $stable(flag_sign)));

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (flag_zero == (result == '0)));

    assert_sign_flag_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (flag_sign == result[W-1]));

    assert_add_overflow_rule_R5: assert property (@(posedge clk) disable iff (rst)
        (start && opcode == 2'b00) |=>
            (flag_ovf == (($past(op_a[W-1]) == $past(op_c[W-1]))
                          && (result[W-1] != $past(op_a[W-1])))));

    assert_mac_product_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (start && opcode == 2'b10 && op_a == MAX_POS && op_b == TWO && op_c == '0)
            |=> flag_ovf);
endmodule

bind smacc_unit smacc_unit_chk #(.W(W)) i_chk (.*);

// File: tb/test_smacc_unit.sv
`timescale 1ns/1ps
module test_smacc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  opcode = 2'b00;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] op_c = '0;
    logic [31:0] result;
    logic        done, flag_ovf, flag_carry, flag_zero, flag_sign;

    int checks = 0;
    int errors = 0;
    bit edge_seen = 1'b0;

    logic [31:0] exp_res = '0;
    logic        exp_done = 1'b0, exp_ovf = 1'b0, exp_carry = 1'b0;
    logic        exp_zero = 1'b0, exp_sign = 1'b0;
    logic [1:0]  last_op = 2'b00;
    bit          in_reset = 1'b1;

    always #2.5 clk = ~clk;

    smacc_unit i_smacc_unit (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .result(result), .done(done), .flag_ovf(flag_ovf),
        .flag_carry(flag_carry), .flag_zero(flag_zero), .flag_sign(flag_sign)
    );

    // Behavioural reference: wide integer arithmetic evaluated at each edge.
    always @(posedge clk) begin
        longint prod, sx, sc, s, ux, uc;
        logic [31:0] x;
        bit is_mul, is_sub, povf;
        edge_seen = 1'b1;
        in_reset  = rst;
        if (rst) begin
            exp_res = '0; exp_done = 0; exp_ovf = 0; exp_carry = 0; exp_zero = 0; exp_sign = 0;
        end else begin
            exp_done = start;
            if (start) begin
                is_mul = opcode[1];
                is_sub = opcode[0];
                prod = longint'($signed(op_a)) * longint'($signed(op_b));
                povf = (prod > 64'sd2147483647) || (prod < -64'sd2147483648);
                x  = is_mul ? prod[31:0] : op_a;
                sx = longint'($signed(x));
                sc = longint'($signed(op_c));
                s  = is_sub ? sx - sc : sx + sc;
                exp_res   = s[31:0];
                exp_ovf   = (s > 64'sd2147483647) || (s < -64'sd2147483648) || (is_mul && povf);
                ux = longint'({32'b0, x});
                uc = longint'({32'b0, op_c});
                exp_carry = is_sub ? (ux >= uc) : (((ux + uc) >> 32) != 0);
                exp_zero  = (exp_res == 32'h0);
                exp_sign  = exp_res[31];
                last_op   = opcode;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (edge_seen) begin
            string rtag;
            if (in_reset || (!exp_done && exp_res == '0 && !exp_ovf && !exp_carry && !exp_zero)) rtag = "R1";
            else rtag = "R10";
            if (exp_done)
                case (last_op)
                    2'b00, 2'b01: rtag = "R2";
                    2'b10:        rtag = "R3";
                    default:      rtag = "R4";
                endcase
            check(in_reset ? "R1 done" : "R9 done", {31'b0, done}, {31'b0, exp_done});
            check({rtag, " result"}, result, exp_res);
            check(last_op[1] ? "R6 overflow" : "R5 overflow", {31'b0, flag_ovf}, {31'b0, exp_ovf});
            check("R8 carry", {31'b0, flag_carry}, {31'b0, exp_carry});
            check("R7 zero", {31'b0, flag_zero}, {31'b0, exp_zero});
            check("R7 sign", {31'b0, flag_sign}, {31'b0, exp_sign});
        end
    end

    task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        @(negedge clk);
        start = 1'b1; opcode = op; op_a = a; op_b = b; op_c = c;
    endtask

    // Idle cycles with scrambled operands: outputs must not move (R10).
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0; opcode = 2'($urandom); op_a = $urandom; op_b = $urandom; op_c = $urandom;
        end
    endtask

    logic [31:0] corners [6] = '{32'h7FFFFFFF, 32'h80000000, 32'h0, 32'hFFFFFFFF, 32'h2, 32'h1};

    initial begin
        repeat (4) @(negedge clk);
        @(negedge clk); rst = 1'b0;          // R1: reset values checked each cycle
        idle(2);
        issue(2'b10, 32'h7FFFFFFF, 32'h2, 32'h0);   // R6 product overflow corner
        idle(1);
        issue(2'b00, 32'h7FFFFFFF, 32'h1234, 32'h1); // R5 add wrap, R2 B ignored
        issue(2'b01, 32'h0, 32'hFFFF, 32'h80000000); // R5 subtract of minimum
        issue(2'b11, 32'h10000, 32'h10000, 32'h0);   // R4 product 2^32
        idle(2);
        for (int op = 0; op < 4; op++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    for (int k = 0; k < 6; k++)
                        issue(2'(op), corners[i], corners[j], corners[k]);
        idle(3);
        for (int n = 0; n < 3000; n++) begin
            issue(2'($urandom), $urandom, ($urandom % 3 == 0) ? ($urandom & 32'hFFFF) : $urandom, $urandom);
            if ($urandom % 4 == 0) idle(1 + $urandom % 3);
        end
        idle(3);
        @(negedge clk); rst = 1'b1;
        idle(2);
        @(negedge clk); rst = 1'b0;
        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule